// File: doc/BRIEF.md
# Prescaled Timer Counter

This block is the timebase of a general-purpose timer. It picks one of five synchronous tick enables (peripheral, high-frequency reference, external pin, low-frequency reference, oscillator) and divides it by a programmable ratio. It then advances an up-counter once per divided tick. The oscillator tick goes through its own small pre-divider before the source selector. Because of that, the oscillator path has two dividers in cascade.

Software drives the block through three write ports:
- a control word: enable, enable mode, free-run or restart mode, source, rollover interrupt enable, and software reset;
- a divider word: main divider and oscillator pre-divider, each stored as ratio minus one;
- a rollover-flag clear strobe.

A compare unit can pulse `restart_i` to return the count to zero when the block is in restart mode. The counter, the rollover flag, the interrupt, the oscillator-enable indication and the reset-busy bit are all visible at the ports.

Top module: `prescaled_timer`

## Requirements
- R1: Source code 1 selects the peripheral tick, 2 the high-frequency tick, 3 the external tick, 4 the low-frequency tick and 5 the divided oscillator tick. Code 0, 6 or 7 stops counting, and the count holds.
- R2: With main divider field P (0..2^PSC_W-1), the counter advances once per P+1 selected ticks.
- R3: With oscillator field Q and main field P, source 5 advances the counter once per (Q+1)(P+1) oscillator ticks.
- R4: `osc_en_o` is 1 exactly when the stored source code is 5. It follows a control write on the next cycle.
- R5: An increment at the all-ones count gives 0 and sets `rov_flag_o`. `irq_o` equals the flag ANDed with the interrupt enable.
- R6: A pulse on `stat_clr_i` clears the flag on the next edge unless a rollover happens in the same cycle. Without the pulse the flag holds.
- R7: A control write that turns the timer on while enable-mode is 1 zeroes the count and both divider phases. With enable-mode 0 the count is kept.
- R8: In restart mode (free-run bit 0) a `restart_i` pulse while enabled makes the count 0 on the next cycle. In free-run mode `restart_i` has no effect.
- R9: A control write with the reset bit set raises `swr_busy_o` for exactly one cycle. At the end of that cycle all control, divider, phase, count and flag state is at its default (all zero), and the other fields of that write are ignored.
- R10: While the enable bit is 0, the count and the divider phases hold and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_per_i | input | 1 | Peripheral tick enable |
| tick_hf_i | input | 1 | High-frequency reference tick enable |
| tick_ext_i | input | 1 | External pin tick enable |
| tick_lf_i | input | 1 | Low-frequency reference tick enable |
| tick_osc_i | input | 1 | Oscillator tick enable |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_en_i | input | 1 | Timer enable |
| ctrl_enmode_i | input | 1 | 1: clear count when enabled |
| ctrl_freerun_i | input | 1 | 1: free-run, 0: restart mode |
| ctrl_src_i | input | 3 | Source code |
| ctrl_rov_ie_i | input | 1 | Rollover interrupt enable |
| ctrl_swr_i | input | 1 | Software reset request |
| psc_we_i | input | 1 | Divider word write strobe |
| psc_div_i | input | PSC_W | Main divider minus one |
| psc_osc_div_i | input | OSC_W | Oscillator pre-divider minus one |
| stat_clr_i | input | 1 | Rollover flag clear (write-one) |
| restart_i | input | 1 | Restart request from compare |
| count_o | output | CNT_W | Counter value |
| rov_flag_o | output | 1 | Rollover flag |
| irq_o | output | 1 | Rollover interrupt |
| swr_busy_o | output | 1 | Software reset in progress |
| osc_en_o | output | 1 | Oscillator path enabled |

## Verification
The bench steps a behavioural model every cycle. It also targets these corners:
- The all-ones to zero wrap. A design with an off-by-one in the flag would set it a cycle early, or not at all.
- Cascaded division on the oscillator path. A swapped or missing stage would show the wrong rate.
- Enabling with enable-mode 0 versus 1. Getting this wrong either drops the held count or fails to clear it.
- `restart_i` in free-run mode, which a wrongly gated design would honour.
- The software reset. A sticky busy bit, or a reset that spares the dividers or the flag, shows up as a miscompare in the cycles that follow.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [2:0] {
    SRC_OFF = 3'd0,
    SRC_PER = 3'd1,
    SRC_HF  = 3'd2,
    SRC_EXT = 3'd3,
    SRC_LF  = 3'd4,
    SRC_OSC = 3'd5
  } tsrc_e;

  typedef struct packed {
    logic  en;
    logic  enmode;
    logic  freerun;
    logic  rov_ie;
    tsrc_e src;
  } ctrl_t;

  localparam ctrl_t CTRL_DEFAULT = '{en: 1'b0, enmode: 1'b0, freerun: 1'b0,
                                     rov_ie: 1'b0, src: SRC_OFF};
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import ptmr_pkg::*;
#(
  parameter int OSC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             osc_en_i,
  input  tsrc_e            src_i,
  input  logic [OSC_W-1:0] osc_div_i,
  input  logic             clr_i,
  input  logic             tick_per_i,
  input  logic             tick_hf_i,
  input  logic             tick_ext_i,
  input  logic             tick_lf_i,
  input  logic             tick_osc_i,
  output logic             sel_tick_o
);
  logic [OSC_W-1:0] oph_q;
  logic             osc_adv, osc_fire, mux_tick;

  assign osc_adv  = run_i & osc_en_i & tick_osc_i;
  assign osc_fire = osc_adv & (oph_q >= osc_div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      oph_q <= '0;
    else if (clr_i)   oph_q <= '0;
    else if (osc_adv) oph_q <= osc_fire ? '0 : oph_q + 1'b1;
  end

  always_comb begin
    unique case (src_i)
      SRC_PER: mux_tick = tick_per_i;
      SRC_HF:  mux_tick = tick_hf_i;
      SRC_EXT: mux_tick = tick_ext_i;
      SRC_LF:  mux_tick = tick_lf_i;
      SRC_OSC: mux_tick = osc_fire;
      default: mux_tick = 1'b0;
    endcase
  end

  assign sel_tick_o = run_i & mux_tick;

  assert_osc_phase_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_fire && !clr_i) |=> (oph_q == '0));
  assert_osc_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(oph_q));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [PSC_W-1:0] div_i,
  input  logic             clr_i,
  output logic             inc_o
);
  logic [PSC_W-1:0] ph_q;

  assign inc_o = tick_i & (ph_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (clr_i)  ph_q <= '0;
    else if (tick_i) ph_q <= inc_o ? '0 : ph_q + 1'b1;
  end

  assert_phase_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_o && !clr_i) |=> (ph_q == '0));
  assert_phase_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(ph_q));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             restart_i,
  input  logic             clr_i,
  input  logic             soft_rst_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, wrap;

  assign wrap = inc_i & ~restart_i & ~clr_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (inc_i)     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (soft_rst_i) flag_q <= 1'b0;
    else if (wrap)       flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  assert_wrap_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !soft_rst_i) |=> (flag_o && cnt_o == '0));
  assert_restart_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !clr_i) |=> (cnt_o == '0));
  assert_count_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !restart_i && !clr_i) |=> $stable(cnt_o));
  assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !wrap) |=> !flag_o);
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 12,
  parameter int OSC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_per_i,
  input  logic             tick_hf_i,
  input  logic             tick_ext_i,
  input  logic             tick_lf_i,
  input  logic             tick_osc_i,
  input  logic             ctrl_we_i,
  input  logic             ctrl_en_i,
  input  logic             ctrl_enmode_i,
  input  logic             ctrl_freerun_i,
  input  logic [2:0]       ctrl_src_i,
  input  logic             ctrl_rov_ie_i,
  input  logic             ctrl_swr_i,
  input  logic             psc_we_i,
  input  logic [PSC_W-1:0] psc_div_i,
  input  logic [OSC_W-1:0] psc_osc_div_i,
  input  logic             stat_clr_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] count_o,
  output logic             rov_flag_o,
  output logic             irq_o,
  output logic             swr_busy_o,
  output logic             osc_en_o
);
  ctrl_t            ctrl_q;
  logic             swr_q, osc_en_q;
  logic [PSC_W-1:0] div_q;
  logic [OSC_W-1:0] odiv_q;
  logic             ctrl_load, en_clear, phase_clr, sel_tick, inc, restart_g;

  assign ctrl_load = ctrl_we_i & ~swr_q & ~ctrl_swr_i;
  // rising enable with clear-on-enable mode
  assign en_clear  = ctrl_load & ~ctrl_q.en & ctrl_en_i & ctrl_enmode_i;
  assign phase_clr = swr_q | en_clear;
  assign restart_g = ctrl_q.en & ~ctrl_q.freerun & restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_DEFAULT;
      osc_en_q <= 1'b0;
      swr_q    <= 1'b0;
    end else if (swr_q) begin
      ctrl_q   <= CTRL_DEFAULT;
      osc_en_q <= 1'b0;
      swr_q    <= 1'b0;
    end else if (ctrl_we_i) begin
      if (ctrl_swr_i) begin
        swr_q <= 1'b1;
      end else begin
        ctrl_q.en      <= ctrl_en_i;
        ctrl_q.enmode  <= ctrl_enmode_i;
        ctrl_q.freerun <= ctrl_freerun_i;
        ctrl_q.rov_ie  <= ctrl_rov_ie_i;
        ctrl_q.src     <= tsrc_e'(ctrl_src_i);
        osc_en_q       <= (ctrl_src_i == SRC_OSC);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      odiv_q <= '0;
    end else if (swr_q) begin
      div_q  <= '0;
      odiv_q <= '0;
    end else if (psc_we_i) begin
      div_q  <= psc_div_i;
      odiv_q <= psc_osc_div_i;
    end
  end

  tmr_src_sel #(.OSC_W(OSC_W)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl_q.en),
    .osc_en_i   (osc_en_q),
    .src_i      (ctrl_q.src),
    .osc_div_i  (odiv_q),
    .clr_i      (phase_clr),
    .tick_per_i (tick_per_i),
    .tick_hf_i  (tick_hf_i),
    .tick_ext_i (tick_ext_i),
    .tick_lf_i  (tick_lf_i),
    .tick_osc_i (tick_osc_i),
    .sel_tick_o (sel_tick)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (sel_tick),
    .div_i  (div_q),
    .clr_i  (phase_clr),
    .inc_o  (inc)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc),
    .restart_i  (restart_g),
    .clr_i      (phase_clr),
    .soft_rst_i (swr_q),
    .flag_clr_i (stat_clr_i),
    .cnt_o      (count_o),
    .flag_o     (rov_flag_o)
  );

  assign irq_o      = rov_flag_o & ctrl_q.rov_ie;
  assign swr_busy_o = swr_q;
  assign osc_en_o   = osc_en_q;

  assert_swr_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr_busy_o |=> (!swr_busy_o && count_o == '0 && !rov_flag_o && !osc_en_o));
  assert_osc_en_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_o == (ctrl_q.src == SRC_OSC));
  assert_free_run_ignores_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.freerun && !inc && !phase_clr) |=> $stable(count_o));
  assert_no_flag_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.en && !rov_flag_o) |=> !rov_flag_o);
endmodule

// File: tb/tb_prescaled_timer.sv
module tb_prescaled_timer;
  localparam int CNT_W = 8;
  localparam int PSC_W = 12;
  localparam int OSC_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic tick_per, tick_hf, tick_ext, tick_lf, tick_osc;
  logic ctrl_we = 0, ctrl_en = 0, ctrl_enmode = 0, ctrl_fr = 0, ctrl_ie = 0, ctrl_swr = 0;
  logic [2:0] ctrl_src = 0;
  logic psc_we = 0;
  logic [PSC_W-1:0] psc_div = 0;
  logic [OSC_W-1:0] psc_odiv = 0;
  logic stat_clr = 0, restart = 0;
  logic [CNT_W-1:0] count;
  logic rov_flag, irq, swr_busy, osc_en;

  always #4 clk = ~clk;

  prescaled_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .OSC_W(OSC_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tick_per_i(tick_per), .tick_hf_i(tick_hf), .tick_ext_i(tick_ext),
    .tick_lf_i(tick_lf), .tick_osc_i(tick_osc),
    .ctrl_we_i(ctrl_we), .ctrl_en_i(ctrl_en), .ctrl_enmode_i(ctrl_enmode),
    .ctrl_freerun_i(ctrl_fr), .ctrl_src_i(ctrl_src), .ctrl_rov_ie_i(ctrl_ie),
    .ctrl_swr_i(ctrl_swr), .psc_we_i(psc_we), .psc_div_i(psc_div),
    .psc_osc_div_i(psc_odiv), .stat_clr_i(stat_clr), .restart_i(restart),
    .count_o(count), .rov_flag_o(rov_flag), .irq_o(irq),
    .swr_busy_o(swr_busy), .osc_en_o(osc_en)
  );

  int vectors = 0, fails = 0, cyc = 0;
  string cur_req = "R9";
  bit done = 0;

  // behavioural model state
  int m_cnt, m_pc, m_oc, m_p, m_q, m_src;
  bit m_en, m_enmode, m_fr, m_ie, m_swr, m_flag;

  task automatic model_reset();
    m_cnt = 0; m_pc = 0; m_oc = 0; m_p = 0; m_q = 0; m_src = 0;
    m_en = 0; m_enmode = 0; m_fr = 0; m_ie = 0; m_swr = 0; m_flag = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else if (m_swr) model_reset();
    else begin
      bit ofire, sel, inc, wrap;
      ofire = tick_osc && m_en && m_src == 5 && (m_oc >= m_q);
      if (tick_osc && m_en && m_src == 5) m_oc = ofire ? 0 : m_oc + 1;
      case (m_src)
        1: sel = tick_per;
        2: sel = tick_hf;
        3: sel = tick_ext;
        4: sel = tick_lf;
        5: sel = ofire;
        default: sel = 0;
      endcase
      sel = sel && m_en;
      inc = sel && (m_pc >= m_p);
      if (sel) m_pc = inc ? 0 : m_pc + 1;
      wrap = 0;
      if (m_en && !m_fr && restart) m_cnt = 0;
      else if (inc) begin
        if (m_cnt == CMAX) begin m_cnt = 0; wrap = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (wrap) m_flag = 1;
      else if (stat_clr) m_flag = 0;
      if (ctrl_we) begin
        if (ctrl_swr) m_swr = 1;
        else begin
          if (!m_en && ctrl_en && ctrl_enmode) begin m_cnt = 0; m_pc = 0; m_oc = 0; end
          m_en = ctrl_en; m_enmode = ctrl_enmode; m_fr = ctrl_fr;
          m_ie = ctrl_ie; m_src = int'(ctrl_src);
        end
      end
      if (psc_we) begin m_p = int'(psc_div); m_q = int'(psc_odiv); end
    end
  end

  task automatic check(int act, int exp, string req);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // compare against model, then drive tick pattern for the next edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(int'(count), m_cnt, cur_req);
      check(int'(rov_flag), int'(m_flag), cur_req);
      check(int'(irq), int'(m_flag && m_ie), cur_req);
      check(int'(swr_busy), int'(m_swr), cur_req);
      check(int'(osc_en), int'(m_src == 5), cur_req);
    end
    tick_per = 1'b1;
    tick_hf  = (cyc % 2) == 0;
    tick_ext = (cyc % 3) == 0;
    tick_lf  = (cyc % 5) == 0;
    tick_osc = 1'b1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      summary();
    end
  end

  task automatic wr_ctrl(bit en, bit enmode, bit fr, int src, bit ie, bit swr);
    @(negedge clk);
    ctrl_we = 1; ctrl_en = en; ctrl_enmode = enmode; ctrl_fr = fr;
    ctrl_src = 3'(src); ctrl_ie = ie; ctrl_swr = swr;
    @(negedge clk);
    ctrl_we = 0; ctrl_swr = 0;
  endtask

  task automatic wr_psc(int p, int q);
    @(negedge clk);
    psc_we = 1; psc_div = PSC_W'(p); psc_odiv = OSC_W'(q);
    @(negedge clk);
    psc_we = 0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c0;
    tick_per = 0; tick_hf = 0; tick_ext = 0; tick_lf = 0; tick_osc = 0;
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R9";
    check(int'(count), 0, "R9 reset count");
    check(int'(osc_en), 0, "R9 reset osc_en");

    cur_req = "R2";
    wr_psc(0, 0);
    wr_ctrl(1, 1, 1, 1, 0, 0);
    check(int'(count), 0, "R7 clear on enable");
    wait_n(20);
    check(int'(count), 20, "R2 divide by 1");
    wr_psc(3, 0);
    c0 = int'(count);
    wait_n(40);
    check(int'(count), c0 + 10, "R2 divide by 4");

    cur_req = "R1";
    wr_ctrl(1, 1, 1, 0, 0, 0);
    c0 = int'(count);
    wait_n(10);
    check(int'(count), c0, "R1 source off holds");
    wr_ctrl(1, 1, 1, 7, 0, 0);
    c0 = int'(count);
    wait_n(10);
    check(int'(count), c0, "R1 code 7 holds");
    for (int s = 2; s <= 4; s++) begin
      wr_ctrl(1, 1, 1, s, 0, 0);
      wait_n(30);
    end

    cur_req = "R3";
    wr_ctrl(0, 0, 1, 4, 0, 0);
    wr_psc(1, 2);
    wr_ctrl(1, 1, 1, 5, 0, 0);
    check(int'(count), 0, "R3 start");
    check(int'(osc_en), 1, "R4 osc source");
    wait_n(60);
    check(int'(count), 10, "R3 cascaded divide by 6");

    cur_req = "R4";
    wr_ctrl(1, 1, 1, 1, 0, 0);
    check(int'(osc_en), 0, "R4 non-osc source");

    cur_req = "R10";
    wr_ctrl(0, 1, 1, 1, 0, 0);
    c0 = int'(count);
    wait_n(20);
    check(int'(count), c0, "R10 disabled hold");
    check(int'(rov_flag), 0, "R10 no flag");

    cur_req = "R7";
    wr_ctrl(1, 0, 1, 1, 0, 0);
    check(int'(count), c0, "R7 keep on enable");

    cur_req = "R5";
    wr_psc(0, 0);
    wr_ctrl(0, 1, 1, 1, 1, 0);
    wr_ctrl(1, 1, 1, 1, 1, 0);
    check(int'(count), 0, "R5 start");
    wait_n(CMAX);
    check(int'(count), CMAX, "R5 at max");
    check(int'(rov_flag), 0, "R5 flag before wrap");
    wait_n(1);
    check(int'(count), 0, "R5 wrap");
    check(int'(rov_flag), 1, "R5 flag set");
    check(int'(irq), 1, "R5 irq");
    wr_ctrl(1, 1, 1, 1, 0, 0);
    check(int'(irq), 0, "R5 irq masked");
    check(int'(rov_flag), 1, "R6 flag holds");

    cur_req = "R6";
    stat_clr = 1;
    @(negedge clk);
    stat_clr = 0;
    check(int'(rov_flag), 0, "R6 flag cleared");

    cur_req = "R8";
    wr_ctrl(1, 1, 0, 1, 0, 0);
    wait_n(5);
    restart = 1;
    @(negedge clk);
    restart = 0;
    check(int'(count), 0, "R8 restart clears");
    wr_ctrl(1, 1, 1, 1, 0, 0);
    wait_n(3);
    c0 = int'(count);
    restart = 1;
    @(negedge clk);
    restart = 0;
    check(int'(count), c0 + 1, "R8 free-run ignores restart");

    cur_req = "R9";
    wr_psc(2, 3);
    wr_ctrl(1, 1, 1, 5, 1, 0);
    wait_n(20);
    wr_ctrl(1, 1, 1, 5, 1, 1);
    check(int'(swr_busy), 1, "R9 busy");
    @(negedge clk);
    check(int'(swr_busy), 0, "R9 self-clear");
    check(int'(count), 0, "R9 count default");
    check(int'(osc_en), 0, "R9 source default");
    wait_n(10);
    check(int'(count), 0, "R9 stays stopped");
    wait_n(2);
    summary();
  end
endmodule